// File: doc/BRIEF.md
# Read-Sequence Command Detector

This block sits beside a byte-wide static memory with a 15-bit address (32768 bytes). It watches completed access cycles and looks for a fixed pattern of six reads. The first five reads form an arming preamble. The sixth read chooses one of two commands. One command saves the working array into nonvolatile storage. The other reloads the array from that storage. When the pattern completes, the detector raises a one-cycle request toward the transfer engine.

Because the pattern is made only of reads, a host can trigger a command through an ordinary memory port without any extra pins. Any write breaks the pattern, and so does any read that does not match the next expected address. While the transfer engine reports busy, every access is ignored. The output-enable pin of the memory plays no part, so the block has no input for it.

Top module: `rdseq_cmd_detect`

## Requirements
- R1: The preamble is five reads, in this order, of the 15-bit addresses 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F. An access counts when accValid is high in a clock cycle, and it is a read when accWrite is low.
- R2: A read of 0x0FC0 directly after a complete preamble drives storeReq high for exactly one cycle. That cycle is the one after the clock edge that sampled the read.
- R3: A read of 0x0C63 directly after a complete preamble drives recallReq high for exactly one cycle, with the same timing as R2.
- R4: A write access at any step aborts the sequence. No request follows, and a fresh full sequence is needed afterwards.
- R5: A read that does not match the expected next address aborts the sequence. If that read is 0x0E38, it counts as step one of a new sequence. Any other address returns the detector to idle.
- R6: A single access advances the detector by at most one step.
- R7: While xferBusy is high, accesses are ignored and the detector is forced back to idle. No request is raised in the following cycle.
- R8: While rstN is low at a clock edge, the detector goes to idle. storeReq and recallReq are low in the cycle that follows.
- R9: Cycles with accValid low leave the progress through the sequence unchanged.
- R10: storeReq and recallReq are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| accValid | input | 1 | One completed memory access in this cycle |
| accWrite | input | 1 | The access is a write (1) or a read (0) |
| accAddr | input | 15 | Byte address of the access |
| xferBusy | input | 1 | The transfer engine is running a save or a reload |
| storeReq | output | 1 | One-cycle request to save the array |
| recallReq | output | 1 | One-cycle request to reload the array |

## Verification
Clean store and recall sequences, including versions padded with idle cycles, show that both final addresses are decoded and that gaps are tolerated. Sequences broken by a write, by a wrong address, or by a stray 0x0E38 separate a plain abort from an abort that restarts at step one. A doubled first address shows that one access never counts twice. Busy pulses and a reset in the middle of a sequence check that progress is discarded. Random traffic, weighted toward the seven special addresses, mixes all of these cases against a step-by-step reference model.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
  localparam int ADDR_W   = 15;
  localparam int PRE_LEN  = 5;
  localparam int STEP_W   = $clog2(PRE_LEN + 1);

  localparam logic [ADDR_W-1:0] STORE_ADDR  = 15'h0FC0;
  localparam logic [ADDR_W-1:0] RECALL_ADDR = 15'h0C63;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic advance;
    logic restart;
    logic fireStore;
    logic fireRecall;
  } seqStrobe_t;

  function automatic logic [ADDR_W-1:0] preambleAddr(input int idx);
    case (idx)
      0:       return 15'h0E38;
      1:       return 15'h31C7;
      2:       return 15'h03E0;
      3:       return 15'h3C1F;
      4:       return 15'h303F;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/rdseq_datapath.sv
module rdseq_datapath
  import rdseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] accAddr,
  input  seqStrobe_t        strb,
  output logic              stepHit,
  output logic              firstHit,
  output logic              storeHit,
  output logic              recallHit,
  output logic              atFinal,
  output logic              storeReq,
  output logic              recallReq
);
  logic [STEP_W-1:0]  stepCnt;
  logic [PRE_LEN-1:0] preHit;

  // one comparator for each preamble address
  for (genvar i = 0; i < PRE_LEN; i++) begin : g_cmp
    assign preHit[i] = (accAddr == preambleAddr(i));
  end

  assign firstHit  = preHit[0];
  assign storeHit  = (accAddr == STORE_ADDR);
  assign recallHit = (accAddr == RECALL_ADDR);
  assign atFinal   = (stepCnt == STEP_W'(PRE_LEN));

  always_comb begin
    stepHit = 1'b0;
    for (int i = 0; i < PRE_LEN; i++) begin
      if (stepCnt == STEP_W'(i)) stepHit = preHit[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepCnt   <= '0;
      storeReq  <= 1'b0;
      recallReq <= 1'b0;
    end else begin
      storeReq  <= strb.fireStore;
      recallReq <= strb.fireRecall;
      if (strb.clear)        stepCnt <= '0;
      else if (strb.restart) stepCnt <= STEP_W'(1);
      else if (strb.advance) stepCnt <= stepCnt + STEP_W'(1);
    end
  end
endmodule

// File: rtl/rdseq_ctrl.sv
module rdseq_ctrl
  import rdseq_pkg::*;
(
  input  logic       accValid,
  input  logic       accWrite,
  input  logic       xferBusy,
  input  logic       stepHit,
  input  logic       firstHit,
  input  logic       storeHit,
  input  logic       recallHit,
  input  logic       atFinal,
  output seqStrobe_t strb
);
  always_comb begin
    strb = '0;
    if (xferBusy) begin
      strb.clear = 1'b1;
    end else if (accValid) begin
      if (accWrite) begin
        strb.clear = 1'b1;
      end else if (atFinal) begin
        if (storeHit) begin
          strb.fireStore = 1'b1;
          strb.clear     = 1'b1;
        end else if (recallHit) begin
          strb.fireRecall = 1'b1;
          strb.clear      = 1'b1;
        end else if (firstHit) begin
          strb.restart = 1'b1;
        end else begin
          strb.clear = 1'b1;
        end
      end else if (stepHit) begin
        strb.advance = 1'b1;
      end else if (firstHit) begin
        strb.restart = 1'b1;
      end else begin
        strb.clear = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rdseq_cmd_detect.sv
module rdseq_cmd_detect
  import rdseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              xferBusy,
  output logic              storeReq,
  output logic              recallReq
);
  seqStrobe_t strb;
  logic stepHit, firstHit, storeHit, recallHit, atFinal;

  rdseq_ctrl u_ctrl (
    .accValid (accValid),
    .accWrite (accWrite),
    .xferBusy (xferBusy),
    .stepHit  (stepHit),
    .firstHit (firstHit),
    .storeHit (storeHit),
    .recallHit(recallHit),
    .atFinal  (atFinal),
    .strb     (strb)
  );

  rdseq_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .accAddr  (accAddr),
    .strb     (strb),
    .stepHit  (stepHit),
    .firstHit (firstHit),
    .storeHit (storeHit),
    .recallHit(recallHit),
    .atFinal  (atFinal),
    .storeReq (storeReq),
    .recallReq(recallReq)
  );
endmodule

// File: rtl/rdseq_chk.sv
module rdseq_chk
  import rdseq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic              accWrite,
  input logic [ADDR_W-1:0] accAddr,
  input logic              xferBusy,
  input logic              storeReq,
  input logic              recallReq
);
  a_r2_store_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(storeReq) |-> $past(accValid && !accWrite && !xferBusy && accAddr == STORE_ADDR));

  a_r3_recall_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(recallReq) |-> $past(accValid && !accWrite && !xferBusy && accAddr == RECALL_ADDR));

  a_r2_store_single: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |=> !storeReq);

  a_r3_recall_single: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |=> !recallReq);

  a_r4_write_no_req: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accWrite) |=> !storeReq && !recallReq);

  a_r7_busy_no_req: assert property (@(posedge clk) disable iff (!rstN)
    xferBusy |=> !storeReq && !recallReq);

  a_r9_idle_no_req: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> !storeReq && !recallReq);

  a_r8_reset_quiet: assert property (@(posedge clk)
    $rose(rstN) |-> !storeReq && !recallReq);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(storeReq && recallReq));
endmodule

bind rdseq_cmd_detect rdseq_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .accValid (accValid),
  .accWrite (accWrite),
  .accAddr  (accAddr),
  .xferBusy (xferBusy),
  .storeReq (storeReq),
  .recallReq(recallReq)
);

// File: tb/rdseq_cmd_detect_tb_top.sv
module rdseq_cmd_detect_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [14:0] accAddr = '0;
  logic        xferBusy = 1'b0;
  logic        storeReq, recallReq;

  int vecCnt = 0;
  int errCnt = 0;
  int mStep = 0;
  logic expStore = 1'b0;
  logic expRecall = 1'b0;

  always #2 clk = ~clk;

  rdseq_cmd_detect dut_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accAddr(accAddr), .xferBusy(xferBusy),
    .storeReq(storeReq), .recallReq(recallReq)
  );

  // 0..4 preamble, 5 store, 6 recall
  function automatic logic [14:0] seqAddr(input int k);
    logic [14:0] tbl [7] = '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F,
                              15'h303F, 15'h0FC0, 15'h0C63};
    return tbl[k];
  endfunction

  task automatic modelStep(input logic v, input logic w, input logic [14:0] a,
                           input logic b, input logic rst);
    expStore = 1'b0;
    expRecall = 1'b0;
    if (rst || b) mStep = 0;
    else if (v) begin
      if (w) mStep = 0;
      else if (mStep == 5 && a == seqAddr(5)) begin expStore = 1'b1; mStep = 0; end
      else if (mStep == 5 && a == seqAddr(6)) begin expRecall = 1'b1; mStep = 0; end
      else if (mStep < 5 && a == seqAddr(mStep)) mStep = mStep + 1;
      else if (a == seqAddr(0)) mStep = 1;
      else mStep = 0;
    end
  endtask

  task automatic apply(input logic v, input logic w, input logic [14:0] a,
                       input logic b, input logic rst, input string tag);
    @(negedge clk);
    accValid = v; accWrite = w; accAddr = a; xferBusy = b; rstN = !rst;
    modelStep(v, w, a, b, rst);
    @(posedge clk);
    #1;
    vecCnt++;
    if (storeReq !== expStore || recallReq !== expRecall) begin
      errCnt++;
      $display("FAIL %s: store/recall got %b%b expected %b%b (addr %h)",
               tag, storeReq, recallReq, expStore, expRecall, a);
    end
  endtask

  task automatic rd(input int k, input string tag);
    apply(1'b1, 1'b0, seqAddr(k), 1'b0, 1'b0, tag);
  endtask

  task automatic preamble(input string tag);
    for (int k = 0; k < 5; k++) rd(k, tag);
  endtask

  initial begin
    #400000;
    errCnt++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    // R8 reset state
    apply(1'b0, 1'b0, '0, 1'b0, 1'b1, "R8 reset");
    apply(1'b0, 1'b0, '0, 1'b0, 1'b1, "R8 reset");
    // R1 R2 store
    preamble("R1 preamble");
    rd(5, "R2 store");
    // R3 recall
    preamble("R1 preamble");
    rd(6, "R3 recall");
    // R9 idle gaps between steps
    for (int k = 0; k < 5; k++) begin
      rd(k, "R9 gap");
      apply(1'b0, 1'b1, 15'h7FFF, 1'b0, 1'b0, "R9 idle");
    end
    rd(5, "R9 store after gaps");
    // R4 write with a matching address
    rd(0, "R4"); rd(1, "R4");
    apply(1'b1, 1'b1, seqAddr(2), 1'b0, 1'b0, "R4 write");
    rd(3, "R4"); rd(4, "R4"); rd(5, "R4 no store");
    // R4 write at final step
    preamble("R4");
    apply(1'b1, 1'b1, seqAddr(5), 1'b0, 1'b0, "R4 final write");
    rd(5, "R4 no store");
    // R5 wrong address then restart on 0E38
    rd(0, "R5"); rd(1, "R5"); rd(0, "R5 restart");
    for (int k = 1; k < 5; k++) rd(k, "R5");
    rd(6, "R5 recall after restart");
    // R5 plain abort
    rd(0, "R5"); rd(1, "R5");
    apply(1'b1, 1'b0, 15'h1234, 1'b0, 1'b0, "R5 abort");
    rd(2, "R5"); rd(3, "R5"); rd(4, "R5"); rd(5, "R5 no store");
    // R6 doubled first address
    rd(0, "R6"); rd(0, "R6"); preamble("R6"); rd(5, "R6 store");
    // R7 busy mid sequence
    rd(0, "R7"); rd(1, "R7");
    apply(1'b1, 1'b0, seqAddr(2), 1'b1, 1'b0, "R7 busy");
    rd(3, "R7"); rd(4, "R7"); rd(5, "R7 no store");
    preamble("R7"); apply(1'b1, 1'b0, seqAddr(5), 1'b1, 1'b0, "R7 busy final");
    // R8 reset mid sequence
    rd(0, "R8"); rd(1, "R8"); rd(2, "R8");
    apply(1'b1, 1'b0, seqAddr(3), 1'b0, 1'b1, "R8 reset mid");
    rd(4, "R8"); rd(5, "R8 no store");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic v, w, b;
      logic [14:0] a;
      int r;
      if ($urandom_range(0, 39) == 0) begin
        int fin = $urandom_range(5, 6);
        for (int k = 0; k < 5; k++) rd(k, "R1 burst");
        rd(fin, fin == 5 ? "R2 burst" : "R3 burst");
      end
      v = ($urandom_range(0, 9) < 8);
      w = ($urandom_range(0, 19) == 0);
      b = ($urandom_range(0, 49) == 0);
      r = $urandom_range(0, 9);
      a = (r < 8) ? seqAddr($urandom_range(0, 6)) : 15'($urandom);
      apply(v, w, a, b, 1'b0, "R10 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule